// File: doc/BRIEF.md
# Eight-Pin Auxiliary GPIO Controller

This block is a register-mapped controller for eight general-purpose pins. Software on a simple 32-bit register bus (word index, write strobe, read strobe) programs, for each pin, a two-bit drive mode, a digital input-buffer enable, a peripheral-drive enable and a three-bit peripheral source select. An output data register can be written directly, or changed bit by bit through separate set, clear and toggle locations.

For each pin the block produces a pad output value, a pad output enable and an input-buffer enable. The value a pin drives comes from the data register or, when its peripheral enable is on, from one of eight peripheral signals picked by that pin's source select. The drive mode then turns that value into push-pull, open-drain or open-source pad control, or turns the driver off for input. Pad inputs pass through a two-flop synchronizer. They can then be read back, masked by the input-buffer enables.

The bus address is a word index, equal to the byte offset divided by four. Index 0 is the mode word, 1 the input-buffer enables, 2 the peripheral enables, 3 the output data, 4 the input data, and 5, 6 and 7 set, clear and toggle. Indices 8 to 15 are the source selects for pins 0 to 7. Index 16 is the low mode alias and 17 the high mode alias.

Top module: `aux_pin_ctrl`

## Requirements
- R1: After reset every register is zero, so every pin is in push-pull mode driving 0 (pad_oe all ones, pad_out all zeros, pad_ie all zeros), and every read returns 0.
- R2: The mode word (index 0) stores 16 bits, the enable and data vectors (indices 1, 2, 3) store 8 bits, and each source select (index 8+n) stores 3 bits. A write takes effect on the clock edge of the write. Reserved upper bits read as 0. The input data location (index 4) ignores writes.
- R3: Pin n's mode is mode bits [2n+1:2n]. In mode 0 (push-pull) the pin drives its drive value with the output enabled. In mode 1 (input) the output enable and pad_out are 0.
- R4: In mode 2 (open-drain) pad_out is 0, and the output enable is on only when the drive value is 0.
- R5: In mode 3 (open-source) pad_out is 1, and the output enable is on only when the drive value is 1.
- R6: The drive value of pin n is data bit n when peripheral-enable bit n is 0. When that bit is 1, it is peripheral input periph_in[s], where s is pin n's source select. It follows periph_in combinationally.
- R7: A write of 1s to index 5, 6 or 7 sets, clears or inverts the matching data bits on that write's clock edge. Bits written as 0 are unchanged. These indices read as 0.
- R8: Index 16 reads and writes mode bits [7:0], and index 17 reads and writes mode bits [15:8], in their own bits [7:0]. Both act on the same storage as index 0.
- R9: Reading index 4 returns, in bit n, the pad_in value from two clock edges earlier ANDed with input-enable bit n. An input-enable change applies to the very next read.
- R10: Reads of indices 18 to 31 return 0, and writes to them change nothing.
- R11: pad_ie equals the input-buffer enable vector (index 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_idx | input | 5 | Register word index (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when bus_rd is low |
| periph_in | input | 8 | Peripheral signals that the source selects choose from |
| pad_in | input | 8 | Asynchronous pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_ie | output | 8 | Pad digital input-buffer enables |

## Verification
The input-enable write and the arrival of new pad data at the synchronizer can fall in the same cycle. The bench changes pad_in on the same clock edge that writes a new input-enable mask. It then reads the input data on each of the next two cycles. The first read must show the old pad value under the new mask, and the second the new pad value under the new mask. This shows that the mask applies at once while the data lags by two edges. The peripheral-select path is also exercised while its enable is on, with periph_in changing between clock edges. The pad outputs must follow without waiting for a clock.

// File: rtl/aux_pin_pkg.sv
package aux_pin_pkg;
  localparam int NPINS  = 8;
  localparam int SEL_W  = 3;
  localparam int NSRC   = 1 << SEL_W;
  localparam int MODE_W = 2 * NPINS;
  localparam int HALF_W = MODE_W / 2;
  localparam int DW     = 32;
  localparam int IDX_W  = 5;

  // word indices of the register map
  localparam logic [IDX_W-1:0] IDX_MODE = 5'd0;
  localparam logic [IDX_W-1:0] IDX_IEN  = 5'd1;
  localparam logic [IDX_W-1:0] IDX_PEN  = 5'd2;
  localparam logic [IDX_W-1:0] IDX_DOUT = 5'd3;
  localparam logic [IDX_W-1:0] IDX_DIN  = 5'd4;
  localparam logic [IDX_W-1:0] IDX_SET  = 5'd5;
  localparam logic [IDX_W-1:0] IDX_CLR  = 5'd6;
  localparam logic [IDX_W-1:0] IDX_TGL  = 5'd7;
  localparam logic [IDX_W-1:0] IDX_SEL0 = 5'd8;
  localparam logic [IDX_W-1:0] IDX_MLO  = 5'd16;
  localparam logic [IDX_W-1:0] IDX_MHI  = 5'd17;

  typedef enum logic [1:0] {
    PM_PUSH   = 2'd0,
    PM_INPUT  = 2'd1,
    PM_ODRAIN = 2'd2,
    PM_OSRC   = 2'd3
  } pin_mode_e;

  typedef logic [NPINS-1:0][SEL_W-1:0] sel_vec_t;
endpackage

// File: rtl/aux_pin_sync.sv
module aux_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/aux_pin_regs.sv
module aux_pin_regs
  import aux_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  din_masked,
  output logic [MODE_W-1:0] mode_q,
  output logic [NPINS-1:0]  ien_q,
  output logic [NPINS-1:0]  pen_q,
  output logic [NPINS-1:0]  dout_q,
  output sel_vec_t          sel_q
);
  logic [MODE_W-1:0] mode_d;
  logic [NPINS-1:0]  ien_d, pen_d, dout_d;
  sel_vec_t          sel_d;
  logic [NPINS-1:0]  wbits;
  logic              unused_hi;

  assign wbits     = bus_wdata[NPINS-1:0];
  assign unused_hi = ^bus_wdata[DW-1:MODE_W];

  // next-state
  always_comb begin
    mode_d = mode_q;
    ien_d  = ien_q;
    pen_d  = pen_q;
    dout_d = dout_q;
    sel_d  = sel_q;
    case (bus_idx)
      IDX_MODE: mode_d = bus_wdata[MODE_W-1:0];
      IDX_MLO:  mode_d[HALF_W-1:0] = bus_wdata[HALF_W-1:0];
      IDX_MHI:  mode_d[MODE_W-1:HALF_W] = bus_wdata[HALF_W-1:0];
      IDX_IEN:  ien_d  = wbits;
      IDX_PEN:  pen_d  = wbits;
      IDX_DOUT: dout_d = wbits;
      IDX_SET:  dout_d = dout_q | wbits;
      IDX_CLR:  dout_d = dout_q & ~wbits;
      IDX_TGL:  dout_d = dout_q ^ wbits;
      default:  ;
    endcase
    for (int p = 0; p < NPINS; p++) begin
      if (bus_idx == IDX_W'(int'(IDX_SEL0) + p)) sel_d[p] = bus_wdata[SEL_W-1:0];
    end
  end

  // state, clock-enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ien_q  <= '0;
      pen_q  <= '0;
      dout_q <= '0;
      sel_q  <= '0;
    end else if (bus_wr) begin
      mode_q <= mode_d;
      ien_q  <= ien_d;
      pen_q  <= pen_d;
      dout_q <= dout_d;
      sel_q  <= sel_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_idx)
        IDX_MODE: bus_rdata[MODE_W-1:0] = mode_q;
        IDX_MLO:  bus_rdata[HALF_W-1:0] = mode_q[HALF_W-1:0];
        IDX_MHI:  bus_rdata[HALF_W-1:0] = mode_q[MODE_W-1:HALF_W];
        IDX_IEN:  bus_rdata[NPINS-1:0]  = ien_q;
        IDX_PEN:  bus_rdata[NPINS-1:0]  = pen_q;
        IDX_DOUT: bus_rdata[NPINS-1:0]  = dout_q;
        IDX_DIN:  bus_rdata[NPINS-1:0]  = din_masked;
        default:  ;
      endcase
      for (int p = 0; p < NPINS; p++) begin
        if (bus_idx == IDX_W'(int'(IDX_SEL0) + p)) bus_rdata[SEL_W-1:0] = sel_q[p];
      end
    end
  end
endmodule

// File: rtl/aux_pin_drive.sv
module aux_pin_drive
  import aux_pin_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [NPINS-1:0]  pen,
  input  logic [NPINS-1:0]  dout,
  input  sel_vec_t          sel,
  input  logic [NSRC-1:0]   periph,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic      val;
    logic      o_b, e_b;
    pin_mode_e md;

    assign md  = pin_mode_e'(mode[2*g +: 2]);
    assign val = pen[g] ? periph[sel[g]] : dout[g];

    always_comb begin
      o_b = 1'b0;
      e_b = 1'b0;
      case (md)
        PM_PUSH:   begin o_b = val;  e_b = 1'b1; end
        PM_INPUT:  begin o_b = 1'b0; e_b = 1'b0; end
        PM_ODRAIN: begin o_b = 1'b0; e_b = ~val; end
        PM_OSRC:   begin o_b = 1'b1; e_b = val;  end
        default:   ;
      endcase
    end

    assign pad_out[g] = o_b;
    assign pad_oe[g]  = e_b;
  end
endmodule

// File: rtl/aux_pin_ctrl.sv
module aux_pin_ctrl
  import aux_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NSRC-1:0]  periph_in,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_ie
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [MODE_W-1:0] mode_w;
  logic [NPINS-1:0]  ien_w, pen_w, dout_w, pad_sync_w;
  sel_vec_t          sel_w;

  aux_pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pad_in),
    .q     (pad_sync_w)
  );

  aux_pin_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_idx    (bus_idx),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .din_masked (pad_sync_w & ien_w),
    .mode_q     (mode_w),
    .ien_q      (ien_w),
    .pen_q      (pen_w),
    .dout_q     (dout_w),
    .sel_q      (sel_w)
  );

  aux_pin_drive u_drive (
    .mode    (mode_w),
    .pen     (pen_w),
    .dout    (dout_w),
    .sel     (sel_w),
    .periph  (periph_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  assign pad_ie = ien_w;
endmodule

// File: rtl/aux_pin_ctrl_chk.sv
module aux_pin_ctrl_chk
  import aux_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  bus_idx,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [MODE_W-1:0] mode_q,
  input logic [NPINS-1:0]  ien_q,
  input logic [NPINS-1:0]  dout_q
);
  logic [NPINS-1:0] in_mask, od_mask, os_mask;
  logic [1:0]       age_q;

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      in_mask[p] = (mode_q[2*p +: 2] == PM_INPUT);
      od_mask[p] = (mode_q[2*p +: 2] == PM_ODRAIN);
      os_mask[p] = (mode_q[2*p +: 2] == PM_OSRC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  a_r3_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & in_mask) == '0);

  a_r4_odrain_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & od_mask) == '0);

  a_r5_osrc_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & os_mask) == os_mask);

  a_r7_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_idx == IDX_SET) |=> dout_q == ($past(dout_q) | $past(bus_wdata[NPINS-1:0])));

  a_r7_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_idx == IDX_CLR) |=> dout_q == ($past(dout_q) & ~$past(bus_wdata[NPINS-1:0])));

  a_r7_tgl_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_idx == IDX_TGL) |=> dout_q == ($past(dout_q) ^ $past(bus_wdata[NPINS-1:0])));

  a_r7_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_idx == IDX_SET || bus_idx == IDX_CLR || bus_idx == IDX_TGL)) |-> bus_rdata == '0);

  a_r8_alias_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_idx == IDX_MHI) |-> bus_rdata == DW'(mode_q[MODE_W-1:HALF_W]));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_idx > IDX_MHI) |-> bus_rdata == '0);

  if (SYNC_STAGES == 2) begin : g_din
    a_r9_din_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && bus_rd && bus_idx == IDX_DIN) |->
        bus_rdata == DW'($past(pad_in, 2) & ien_q));
  end
endmodule

bind aux_pin_ctrl aux_pin_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_idx   (bus_idx),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .mode_q    (mode_w),
  .ien_q     (ien_w),
  .dout_q    (dout_w)
);

// File: tb/aux_pin_ctrl_test.sv
`timescale 1ns/1ps
module aux_pin_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_idx;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  periph_in, pad_in;
  logic [7:0]  pad_out, pad_oe, pad_ie;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  aux_pin_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_idx(bus_idx), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_in(periph_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie)
  );

  // row: write index, write data, read index, expected read data
  localparam int NROWS = 15;
  localparam logic [73:0] ROWS [NROWS] = '{
    {5'd0,  32'hFFFF_FFFF, 5'd0,  32'h0000_FFFF},  // R2 reserved mode bits
    {5'd16, 32'h0000_0012, 5'd0,  32'h0000_FF12},  // R8 low alias write
    {5'd17, 32'hFFFF_FF3C, 5'd0,  32'h0000_3C12},  // R8 high alias write
    {5'd0,  32'h0000_1234, 5'd16, 32'h0000_0034},  // R8 low alias read
    {5'd0,  32'h0000_1234, 5'd17, 32'h0000_0012},  // R8 high alias read
    {5'd1,  32'hFFFF_FF5A, 5'd1,  32'h0000_005A},  // R2 input enables
    {5'd2,  32'h0000_03C3, 5'd2,  32'h0000_00C3},  // R2 peripheral enables
    {5'd3,  32'h0000_01A5, 5'd3,  32'h0000_00A5},  // R2 data out
    {5'd5,  32'h0000_000F, 5'd3,  32'h0000_00AF},  // R7 set
    {5'd6,  32'h0000_0081, 5'd3,  32'h0000_002E},  // R7 clear
    {5'd7,  32'h0000_00FF, 5'd3,  32'h0000_00D1},  // R7 toggle
    {5'd5,  32'h0000_00FF, 5'd5,  32'h0000_0000},  // R7 set reads zero
    {5'd11, 32'hFFFF_FFFD, 5'd11, 32'h0000_0005},  // R2 source select pin 3
    {5'd20, 32'hFFFF_FFFF, 5'd20, 32'h0000_0000},  // R10 unmapped
    {5'd4,  32'h0000_0000, 5'd3,  32'h0000_00FF}   // R2 input data ignores writes
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] i, input logic [31:0] d);
    @(negedge clk);
    bus_idx = i; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] i, output logic [31:0] v);
    bus_idx = i; bus_rd = 1'b1;
    #1;
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_idx = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    periph_in = '0; pad_in = '0;
    do_reset();

    // R1 reset state
    chk("R1 pad_oe", {24'd0, pad_oe}, 32'hFF);
    chk("R1 pad_out", {24'd0, pad_out}, 32'h00);
    chk("R1 pad_ie", {24'd0, pad_ie}, 32'h00);
    rd(5'd0, rv);  chk("R1 mode read", rv, 32'h0);
    rd(5'd3, rv);  chk("R1 data read", rv, 32'h0);

    // register table
    for (int r = 0; r < NROWS; r++) begin
      wr(ROWS[r][73:69], ROWS[r][68:37]);
      rd(ROWS[r][36:32], rv);
      if (rv !== ROWS[r][31:0])
        $display("  table row %0d (R2/R7/R8/R10)", r);
      chk("R2/R7/R8/R10 table", rv, ROWS[r][31:0]);
    end

    do_reset();
    // R3 push-pull and input
    wr(5'd3, 32'h55);
    chk("R3 push-pull out", {24'd0, pad_out}, 32'h55);
    chk("R3 push-pull oe", {24'd0, pad_oe}, 32'hFF);
    wr(5'd0, 32'h0001);
    chk("R3 input oe", {24'd0, pad_oe}, 32'hFE);
    chk("R3 input out", {24'd0, pad_out}, 32'h54);

    // R4 open-drain
    wr(5'd0, 32'hAAAA);
    wr(5'd3, 32'h0F);
    chk("R4 open-drain oe", {24'd0, pad_oe}, 32'hF0);
    chk("R4 open-drain out", {24'd0, pad_out}, 32'h00);

    // R5 open-source
    wr(5'd0, 32'hFFFF);
    chk("R5 open-source oe", {24'd0, pad_oe}, 32'h0F);
    chk("R5 open-source out", {24'd0, pad_out}, 32'hFF);

    // R6 peripheral selection
    wr(5'd0, 32'h0);
    for (int p = 0; p < 8; p++) wr(5'(8 + p), 32'(p));
    periph_in = 8'h96;
    wr(5'd2, 32'hFF);
    chk("R6 identity select", {24'd0, pad_out}, 32'h96);
    for (int p = 0; p < 8; p++) wr(5'(8 + p), 32'd7);
    chk("R6 all select 7", {24'd0, pad_out}, 32'hFF);
    periph_in = 8'h16;
    #1;
    chk("R6 combinational follow", {24'd0, pad_out}, 32'h00);
    wr(5'd2, 32'hF0);
    chk("R6 mixed data/peripheral", {24'd0, pad_out}, 32'h0F);
    periph_in = 8'h80;
    wr(5'd0, 32'hAAAA);
    chk("R6 open-drain released", {24'd0, pad_oe}, 32'h00);

    // R11 input buffer enable
    wr(5'd1, 32'h3C);
    chk("R11 pad_ie", {24'd0, pad_ie}, 32'h3C);

    // R9 two-edge lag
    wr(5'd1, 32'h0F);
    @(negedge clk); pad_in = 8'hFF;
    @(negedge clk); rd(5'd4, rv); chk("R9 after one edge", rv, 32'h00);
    @(negedge clk); rd(5'd4, rv); chk("R9 after two edges", rv, 32'h0F);

    // R9 enable change in the same cycle as pad change
    @(negedge clk); pad_in = 8'hAA;
    repeat (3) @(negedge clk);
    rd(5'd4, rv); chk("R9 settled", rv, 32'h0A);
    @(negedge clk);
    pad_in = 8'h55; bus_idx = 5'd1; bus_wdata = 32'hF0; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(5'd4, rv); chk("R9 new mask old data", rv, 32'hA0);
    @(negedge clk); rd(5'd4, rv); chk("R9 new mask new data", rv, 32'h50);

    // R10 unmapped write leaves state
    rd(5'd3, rv); chk("R10 data before", rv, 32'h0F);
    wr(5'd31, 32'hFFFF_FFFF);
    rd(5'd3, rv); chk("R10 data unchanged", rv, 32'h0F);
    rd(5'd0, rv); chk("R10 mode unchanged", rv, 32'hAAAA);
    rd(5'd31, rv); chk("R10 unmapped read", rv, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule